// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Coherent Byte Reads

This block is a 16-bit up-counter behind a byte-wide register bus. A power-of-two prescaler sits between the input clock and the counter. A 3-bit select picks a division ratio from 1 to 128. The count is reached as a high byte and a low byte, and each byte has its own read strobe and write strobe.

Software reading a running timer one byte at a time can see a torn value. To prevent this, a read of the high byte also copies the low byte into a holding register in the same clock edge. While the timer runs, a later read of the low byte returns that copy, so the two bytes belong to the same instant. When the count passes the top of its range it restarts at one and raises a single-cycle terminal-count pulse.

Clearing `run_en` freezes the counter and zeroes the prescaler. A restart therefore always waits a full prescale period before the first increment. All pins are plain control or status pins. There is no handshake and no back-pressure: every strobe is acted on at the clock edge that samples it.

Top module: `ptmr_top`

## Requirements
- R1: After reset the count is 0x0001, the holding register is 0x00, `rdata` is 0x00 and `tc_pulse` is 0.
- R2: While `run_en` is 1, the count increases by one every 2^P clocks, where P is the unsigned value of `presc_sel` (0 gives 1, 7 gives 128).
- R3: Every clock edge with `run_en` at 0 zeroes the prescaler. After a restart, the first increment needs a full prescale period.
- R4: A new `presc_sel` value seen while running is taken up only at the edge where the current prescale period ends. The period under way keeps its old length.
- R5: While `run_en` is 0 and no write strobe is high, the count does not change.
- R6: `rd_hi` sampled at an edge puts the high count byte on `rdata` after that edge. If `run_en` is also 1, the same edge copies the low count byte into the holding register. `rd_hi` wins over `rd_lo` when both are high.
- R7: `rd_lo` sampled while `run_en` is 1 puts the holding register on `rdata` after that edge, not the live low byte.
- R8: `rd_lo` sampled while `run_en` is 0 puts the live low count byte on `rdata` after that edge.
- R9: `wr_hi` or `wr_lo` loads `wdata` into the count's high byte or low byte (bits 15:8 or 7:0) at the edge that samples it. The other byte is kept, and counting goes on from the new value.
- R10: At an edge where a write strobe is high, no prescaled increment is applied to the count.
- R11: An increment from 0xFFFF loads 0x0001, and `tc_pulse` is 1 for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Timer run enable |
| presc_sel | input | 3 | Prescale exponent P (divide by 2^P) |
| wr_hi | input | 1 | Write strobe, high count byte |
| wr_lo | input | 1 | Write strobe, low count byte |
| wdata | input | 8 | Write data |
| rd_hi | input | 1 | Read strobe, high count byte |
| rd_lo | input | 1 | Read strobe, low count byte |
| rdata | output | 8 | Read data, valid the cycle after a read strobe |
| tc_pulse | output | 1 | One-cycle pulse after a wrap |

## Verification
The read data and the holding-register copy are due one clock edge after the edge that samples a read strobe. Writes, increments and `tc_pulse` become visible after that same edge. The bench drives strobes on the falling edge, and its monitor compares `rdata` shortly after the following rising edge, against values queued by the driver.

Count results after a run are checked only after `run_en` has dropped, with the number of enabled edges counted exactly. A run of N edges at ratio 2^P must therefore give exactly floor(N / 2^P) increments. The pulse is sampled at the falling edge after each enabled rising edge around the wrap.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  // Source selected for the read data register at a given edge
  typedef enum logic [1:0] {
    RDK_NONE,
    RDK_HIGH,
    RDK_LOW_HOLD,
    RDK_LOW_LIVE
  } rd_kind_e;

  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_PSEL_W = 3;
endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int unsigned PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [PSEL_W-1:0] presc_sel,
  output logic              tick
);
  localparam int unsigned PRE_W = (1 << PSEL_W) - 1;

  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  limit;
  logic [PSEL_W-1:0] pact_q;

  // limit = 2^pact - 1 as a thermometer code
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      limit[i] = (i < int'(pact_q));
    end
  end

  assign tick = run_en && (pre_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      pact_q <= '0;
    end else if (!run_en) begin
      pre_q  <= '0;
      pact_q <= presc_sel;
    end else if (tick) begin
      pre_q  <= '0;
      pact_q <= presc_sel;
    end else begin
      pre_q  <= pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned RESET_VAL = 1,
  parameter int unsigned WRAP_VAL  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  wr_hi,
  input  logic                  wr_lo,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [2*BYTE_W-1:0]   cnt,
  output logic                  tc
);
  localparam int unsigned NLANES = 2;
  localparam int unsigned CNT_W  = NLANES * BYTE_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  wr_next;
  logic [NLANES-1:0] wr_vec;
  logic              any_wr;
  logic              at_top;

  assign wr_vec = {wr_hi, wr_lo};
  assign any_wr = |wr_vec;
  assign at_top = &cnt_q;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign wr_next[g*BYTE_W +: BYTE_W] = wr_vec[g] ? wdata : cnt_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RESET_VAL);
      tc    <= 1'b0;
    end else begin
      tc <= !any_wr && tick && at_top;
      if (any_wr) begin
        cnt_q <= wr_next;
      end else if (tick) begin
        cnt_q <= at_top ? CNT_W'(WRAP_VAL) : cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ptmr_readport.sv
module ptmr_readport
  import ptmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                rd_hi,
  input  logic                rd_lo,
  input  logic [2*BYTE_W-1:0] cnt,
  output logic [BYTE_W-1:0]   rdata
);
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] rdata_q;
  rd_kind_e          kind;

  always_comb begin
    if (rd_hi)       kind = RDK_HIGH;
    else if (!rd_lo) kind = RDK_NONE;
    else if (run_en) kind = RDK_LOW_HOLD;
    else             kind = RDK_LOW_LIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rdata_q <= '0;
    end else begin
      case (kind)
        RDK_HIGH: begin
          rdata_q <= cnt[2*BYTE_W-1:BYTE_W];
          if (run_en) hold_q <= cnt[BYTE_W-1:0];
        end
        RDK_LOW_HOLD: rdata_q <= hold_q;
        RDK_LOW_LIVE: rdata_q <= cnt[BYTE_W-1:0];
        default: ;
      endcase
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int unsigned BYTE_W    = DEF_BYTE_W,
  parameter int unsigned PSEL_W    = DEF_PSEL_W,
  parameter int unsigned RESET_VAL = 1,
  parameter int unsigned WRAP_VAL  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [PSEL_W-1:0] presc_sel,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [BYTE_W-1:0] rdata,
  output logic              tc_pulse
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic             tick;
  logic [CNT_W-1:0] cnt;

  ptmr_prescaler #(.PSEL_W(PSEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .presc_sel(presc_sel), .tick(tick)
  );

  ptmr_count #(.BYTE_W(BYTE_W), .RESET_VAL(RESET_VAL), .WRAP_VAL(WRAP_VAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wdata(wdata), .cnt(cnt), .tc(tc_pulse)
  );

  ptmr_readport #(.BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .rd_hi(rd_hi),
    .rd_lo(rd_lo), .cnt(cnt), .rdata(rdata)
  );
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned WRAP_VAL = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run_en,
  input logic                wr_hi,
  input logic                wr_lo,
  input logic                rd_hi,
  input logic                rd_lo,
  input logic [BYTE_W-1:0]   wdata,
  input logic [BYTE_W-1:0]   rdata,
  input logic                tc_pulse,
  input logic [2*BYTE_W-1:0] cnt
);
  // R11
  tc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

  // R11
  tc_wrap_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (cnt == (2*BYTE_W)'(WRAP_VAL)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_hi && !wr_lo) |=> $stable(cnt));

  // R9
  wr_hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt[2*BYTE_W-1:BYTE_W] == $past(wdata)));

  // R6
  rd_hi_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> (rdata == $past(cnt[2*BYTE_W-1:BYTE_W])));

  // R8
  rd_lo_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi && !run_en) |=> (rdata == $past(cnt[BYTE_W-1:0])));
endmodule

bind ptmr_top ptmr_chk #(.BYTE_W(BYTE_W), .WRAP_VAL(WRAP_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_hi(wr_hi), .wr_lo(wr_lo),
  .rd_hi(rd_hi), .rd_lo(rd_lo), .wdata(wdata), .rdata(rdata),
  .tc_pulse(tc_pulse), .cnt(cnt)
);

// File: tb/ptmr_top_bench.sv
`timescale 1ns/1ps
module ptmr_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [2:0] presc_sel = 3'd0;
  logic       wr_hi = 1'b0, wr_lo = 1'b0, rd_hi = 1'b0, rd_lo = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tc_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  ptmr_top u_ptmr_top (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .presc_sel(presc_sel),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(wdata), .rd_hi(rd_hi),
    .rd_lo(rd_lo), .rdata(rdata), .tc_pulse(tc_pulse)
  );

  task automatic chk(string tag, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit hi, logic [7:0] d);
    wdata = d; wr_hi = hi; wr_lo = !hi;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic rd(bit hi, logic [7:0] expv, string tag);
    exp_q.push_back(expv); tag_q.push_back(tag);
    rd_hi = hi; rd_lo = !hi;
    @(negedge clk);
    rd_hi = 1'b0; rd_lo = 1'b0;
  endtask

  task automatic run_for(int n);
    run_en = 1'b1;
    cyc(n);
    run_en = 1'b0;
    cyc(1);
  endtask

  // Monitor: rdata is due one edge after a sampled read strobe
  always @(posedge clk) begin
    if (rst_n && (rd_hi || rd_lo)) begin
      #1;
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R6: unexpected read, actual 0x%0h expected none", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 tc_pulse", tc_pulse, 0);
    rd(1'b1, 8'h00, "R1 hi");
    rd(1'b0, 8'h01, "R1 lo");
    // R1/R7: hold register still zero, read while running
    run_en = 1'b1;
    rd(1'b0, 8'h00, "R7 hold reset");
    run_en = 1'b0;
    cyc(1);
    rd(1'b1, 8'h00, "R2 hi after one tick");
    rd(1'b0, 8'h02, "R8 live lo");

    // R9 writes
    wr(1'b1, 8'h12);
    wr(1'b0, 8'h34);
    rd(1'b1, 8'h12, "R9 hi");
    rd(1'b0, 8'h34, "R9 lo");

    // R2 P=0: 5 edges -> +5
    run_for(5);
    rd(1'b0, 8'h39, "R2 div1");
    // R2 P=2: 10 edges -> +2
    presc_sel = 3'd2; cyc(1);
    run_for(10);
    rd(1'b1, 8'h12, "R2 div4 hi");
    rd(1'b0, 8'h3B, "R2 div4 lo");
    // R3 two short runs of 3 edges with a stop between -> +0
    run_for(3);
    run_for(3);
    rd(1'b0, 8'h3B, "R3 prescaler cleared");
    // R2 P=7: 256 edges -> +2
    presc_sel = 3'd7; cyc(1);
    run_for(256);
    rd(1'b0, 8'h3D, "R2 div128");

    // R4 change select mid-period: P=1 then 3, 10 edges -> +2
    presc_sel = 3'd1; cyc(1);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h00);
    run_en = 1'b1;
    cyc(1);
    presc_sel = 3'd3;
    cyc(9);
    run_en = 1'b0;
    cyc(1);
    rd(1'b0, 8'h02, "R4 deferred select");
    presc_sel = 3'd0; cyc(1);

    // R6/R7 coherent read while running
    wr(1'b1, 8'h10);
    wr(1'b0, 8'hFE);
    run_en = 1'b1;
    rd(1'b1, 8'h10, "R6 hi snapshot");
    rd(1'b0, 8'hFE, "R7 lo from hold");
    run_en = 1'b0;
    cyc(1);
    rd(1'b1, 8'h11, "R6 hi after run");
    rd(1'b0, 8'h00, "R8 live after run");

    // R11 wrap and pulse
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'hFE);
    run_en = 1'b1;
    cyc(1); chk("R11 no pulse at FFFF", tc_pulse, 0);
    cyc(1); chk("R11 pulse on wrap", tc_pulse, 1);
    cyc(1); chk("R11 pulse one cycle", tc_pulse, 0);
    run_en = 1'b0;
    cyc(1);
    rd(1'b1, 8'h00, "R11 hi after wrap");
    rd(1'b0, 8'h02, "R11 lo after wrap");

    // R10 write beats increment, then counting continues (R9)
    run_en = 1'b1;
    wr(1'b0, 8'h80);
    cyc(2);
    run_en = 1'b0;
    cyc(1);
    rd(1'b0, 8'h82, "R10 write priority");
    // R5 stopped counter holds
    cyc(5);
    rd(1'b0, 8'h82, "R5 hold while stopped");
    rd(1'b1, 8'h00, "R5 hi while stopped");

    cyc(2);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R6: %0d reads unanswered, expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule